// File: doc/BRIEF.md
# Prefix Remapper with Low-Address Protection

This block sits after address translation and takes a real address for one memory access. It decides whether the access is a store into a protected low-storage byte, and it turns the real address into an absolute address by exchanging the first 8 KB of storage with an 8 KB block at a programmable prefix. It also reports when a page touches the protected range, so that a translation cache does not keep write permission for that page.

Requests arrive through a valid/ready handshake and give the address, the access kind, whether dynamic translation is on, the selected address space, the private-space bit of each space and the protection enable bit. Each accepted request produces exactly one registered response. The response carries the absolute address, a protection fault flag with its exception code, the no-cache-write flag, or an unsupported-mode flag. The prefix is held in an internal register and is loaded through a strobe.

Top module: `lap_prefix_unit`

## Requirements
- R1: When protection is active, a store faults exactly for bytes 0x000..0x1FF and 0x1000..0x11FF. Bytes 0x200 and 0x1200 do not fault.
- R2: With `lap_en` low, no access faults. With `lap_en` high and `dat_on` low, protection is active whatever the private bits are.
- R3: With `dat_on` high, protection is active only if the private bit of the selected space is clear. `space_sel` 0 selects primary (`priv_bits[0]`), 1 selects secondary (`priv_bits[1]`) and 2 selects home (`priv_bits[2]`).
- R4: A non-faulting real address below 0x2000 gives the absolute address real + prefix.
- R5: A real address in [prefix, prefix+0x2000) gives real − prefix. Any other address passes through unchanged.
- R6: `rsp_nocache_wr` is high when protection is active and address bits above bit 12 are all zero, which is the page-aligned address 0x0 or 0x1000. This holds whatever the access kind and whether or not it faults.
- R7: On a fault, `rsp_tec` equals the address with bits 11:0 cleared, ORed with 0x400 (store) and 0x080 (low-address), and `rsp_abs` is 0. Without a fault `rsp_tec` is 0.
- R8: Loads (`req_kind`=0) and fetches (`req_kind`=2) never fault. A store is `req_kind`=1.
- R9: After reset the prefix is 0. A cycle with `pfx_load` high stores `pfx_in` with bits 12:0 forced to zero, and requests accepted from the next cycle on use it.
- R10: With `dat_on` high and `space_sel`=3, the response has `rsp_unsupported` high, no fault, no no-cache flag and `rsp_abs`=0. With `dat_on` low, `space_sel`=3 is accepted normally.
- R11: A request accepted at a clock edge is answered with `rsp_valid` from that edge on. The response and `rsp_valid` hold while `rsp_ready` is low, and `req_ready` is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_load | input | 1 | Prefix load strobe |
| pfx_in | input | AW | New prefix value; bits 12:0 are ignored |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Real address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| dat_on | input | 1 | Dynamic translation enabled |
| space_sel | input | 2 | 0 primary, 1 secondary, 2 home, 3 register mode |
| priv_bits | input | 3 | Private-space bits of primary, secondary, home |
| lap_en | input | 1 | Low-address protection enable |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_abs | output | AW | Absolute address |
| rsp_prot_fault | output | 1 | Protection exception |
| rsp_tec | output | AW | Translation-exception code |
| rsp_nocache_wr | output | 1 | Write permission must not be cached |
| rsp_unsupported | output | 1 | Register addressing mode requested |

## Verification
A corrupted prefix register shows on the first remapped address after it: a low address maps to the wrong block, or the prefix block stops mapping to zero. A response register that holds stale data or a valid bit stuck high shows within one cycle as a wrong result or a `req_ready` held low. The bench therefore checks each result in the cycle after the request is accepted and checks the stall case over more than one cycle.

// File: rtl/lap_prefix_unit.sv
module lap_prefix_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pfx_load,
  input  logic [AW-1:0] pfx_in,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  input  logic          dat_on,
  input  logic [1:0]    space_sel,
  input  logic [2:0]    priv_bits,
  input  logic          lap_en,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_abs,
  output logic          rsp_prot_fault,
  output logic [AW-1:0] rsp_tec,
  output logic          rsp_nocache_wr,
  output logic          rsp_unsupported
);
  localparam int SWAP_BITS = 13;
  localparam int PAGE_BITS = 12;
  localparam int LOW_BITS  = 9;
  localparam logic [PAGE_BITS-1:0] TEC_FLAGS = 12'h480;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] SPACE_REG  = 2'd3;

  logic [AW-SWAP_BITS-1:0] pfx_q;
  logic                    accept;
  logic                    unsup, priv_sel, active, low_page, low_byte, fault;
  logic [AW-1:0]           abs_addr;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign unsup    = dat_on && (space_sel == SPACE_REG);
  assign priv_sel = (space_sel == 2'd0) ? priv_bits[0] :
                    (space_sel == 2'd1) ? priv_bits[1] : priv_bits[2];
  assign active   = lap_en && !unsup && (!dat_on || !priv_sel);
  assign low_page = (req_addr[AW-1:SWAP_BITS] == '0);
  assign low_byte = low_page && (req_addr[PAGE_BITS-1:LOW_BITS] == '0);
  assign fault    = active && low_byte && (req_kind == KIND_STORE);

  always_comb begin
    if (low_page)
      abs_addr = {pfx_q, req_addr[SWAP_BITS-1:0]};
    else if (req_addr[AW-1:SWAP_BITS] == pfx_q)
      abs_addr = {{(AW-SWAP_BITS){1'b0}}, req_addr[SWAP_BITS-1:0]};
    else
      abs_addr = req_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pfx_q <= '0;
    else if (pfx_load)
      pfx_q <= pfx_in[AW-1:SWAP_BITS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_abs         <= '0;
      rsp_prot_fault  <= 1'b0;
      rsp_tec         <= '0;
      rsp_nocache_wr  <= 1'b0;
      rsp_unsupported <= 1'b0;
    end else if (accept) begin
      rsp_valid       <= 1'b1;
      rsp_unsupported <= unsup;
      rsp_prot_fault  <= fault;
      rsp_nocache_wr  <= active && low_page;
      rsp_abs         <= (fault || unsup) ? '0 : abs_addr;
      rsp_tec         <= fault ? {req_addr[AW-1:PAGE_BITS], TEC_FLAGS} : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lap_prefix_unit_chk.sv
module lap_prefix_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_abs,
  input logic          rsp_prot_fault,
  input logic [AW-1:0] rsp_tec,
  input logic          rsp_nocache_wr,
  input logic          rsp_unsupported
);
  logic [1:0] kind_q;
  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= 2'd0;
    else if (req_valid && req_ready) kind_q <= req_kind;
  end

  assert_only_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_prot_fault) |-> (kind_q == 2'd1));

  assert_tec_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_prot_fault) |-> (rsp_tec[11:0] == 12'h480 && rsp_abs == '0));

  assert_fault_nocache_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_prot_fault) |-> rsp_nocache_wr);

  assert_unsup_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unsupported) |-> (!rsp_prot_fault && !rsp_nocache_wr));

  assert_stall_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_abs) && $stable(rsp_tec)
                                   && $stable(rsp_prot_fault)));
endmodule

bind lap_prefix_unit lap_prefix_unit_chk #(.AW(AW)) chk (.*);

// File: tb/lap_prefix_unit_test.sv
module lap_prefix_unit_test;
  localparam int AW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic pfx_load = 0;
  logic [AW-1:0] pfx_in = '0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_kind = 0, space_sel = 0;
  logic dat_on = 0, lap_en = 0, rsp_ready = 1;
  logic [2:0] priv_bits = 0;
  logic rsp_valid, rsp_prot_fault, rsp_nocache_wr, rsp_unsupported;
  logic [AW-1:0] rsp_abs, rsp_tec;
  int checks = 0, fails = 0;
  bit done = 0;

  lap_prefix_unit #(.AW(AW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ctl(logic dat, logic [1:0] sp, logic [2:0] pb, logic en);
    dat_on = dat; space_sel = sp; priv_bits = pb; lap_en = en;
  endtask

  task automatic issue(logic [AW-1:0] a, logic [1:0] k);
    @(negedge clk);
    req_addr = a; req_kind = k; req_valid = 1; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_ok(string req, logic [AW-1:0] a, logic [1:0] k,
                           logic [AW-1:0] abs_exp, logic nc);
    issue(a, k);
    check(req, {31'd0, rsp_valid}, 1);
    check(req, {31'd0, rsp_prot_fault}, 0);
    check(req, rsp_abs, abs_exp);
    check(req, {31'd0, rsp_nocache_wr}, {31'd0, nc});
    check(req, rsp_tec, 0);
  endtask

  task automatic expect_fault(string req, logic [AW-1:0] a);
    issue(a, 2'd1);
    check(req, {31'd0, rsp_prot_fault}, 1);
    check(req, rsp_tec, {a[AW-1:12], 12'h000} | 32'h480);
    check(req, rsp_abs, 0);
    check(req, {31'd0, rsp_nocache_wr}, 1);
  endtask

  task automatic load_prefix(logic [AW-1:0] v);
    @(negedge clk); pfx_load = 1; pfx_in = v;
    @(negedge clk); pfx_load = 0;
  endtask

  task automatic t_reset;
    check("R11 reset valid", {31'd0, rsp_valid}, 0);
    check("R11 reset ready", {31'd0, req_ready}, 1);
    set_ctl(0, 0, 0, 0);
    expect_ok("R9 zero prefix", 32'h100, 0, 32'h100, 0);
  endtask

  task automatic t_remap;
    load_prefix(32'h0003_4ABC);
    set_ctl(0, 0, 0, 0);
    expect_ok("R4 low to prefix", 32'h100, 0, 32'h0003_4100, 0);
    expect_ok("R9 low bits ignored", 32'h1FFF, 0, 32'h0003_5FFF, 0);
    expect_ok("R5 prefix to low", 32'h0003_4010, 0, 32'h10, 0);
    expect_ok("R5 prefix top", 32'h0003_5FFF, 2, 32'h1FFF, 0);
    expect_ok("R5 above block", 32'h0003_6000, 0, 32'h0003_6000, 0);
    expect_ok("R5 at 0x2000", 32'h2000, 1, 32'h2000, 0);
  endtask

  task automatic t_bytes;
    set_ctl(0, 0, 0, 1);
    expect_fault("R1 byte 0x1FF", 32'h1FF);
    expect_fault("R1 byte 0x1000", 32'h1000);
    expect_fault("R7 byte 0x11FF", 32'h11FF);
    expect_ok("R6 0x200 no fault", 32'h200, 1, 32'h0003_4200, 1);
    expect_ok("R6 0x1200 no fault", 32'h1200, 1, 32'h0003_5200, 1);
    expect_ok("R6 0x2000 clear", 32'h2000, 1, 32'h2000, 0);
  endtask

  task automatic t_enable;
    set_ctl(0, 0, 0, 0);
    expect_ok("R2 disabled", 32'h10, 1, 32'h0003_4010, 0);
    set_ctl(0, 1, 3'b111, 1);
    expect_fault("R2 dat off private", 32'h10);
    set_ctl(0, 3, 3'b111, 1);
    expect_fault("R10 dat off reg mode", 32'h20);
    check("R10 dat off no unsup", {31'd0, rsp_unsupported}, 0);
  endtask

  task automatic t_space;
    set_ctl(1, 0, 3'b001, 1);
    expect_ok("R3 primary private", 32'h10, 1, 32'h0003_4010, 0);
    set_ctl(1, 0, 3'b110, 1);
    expect_fault("R3 primary shared", 32'h10);
    set_ctl(1, 1, 3'b101, 1);
    expect_fault("R3 secondary shared", 32'h10);
    set_ctl(1, 2, 3'b100, 1);
    expect_ok("R3 home private", 32'h10, 1, 32'h0003_4010, 0);
    set_ctl(1, 2, 3'b011, 1);
    expect_fault("R3 home shared", 32'h10);
  endtask

  task automatic t_kinds;
    set_ctl(0, 0, 0, 1);
    expect_ok("R8 load", 32'h10, 0, 32'h0003_4010, 1);
    expect_ok("R8 fetch", 32'h1010, 2, 32'h0003_5010, 1);
  endtask

  task automatic t_unsup;
    set_ctl(1, 3, 0, 1);
    issue(32'h10, 1);
    check("R10 unsupported", {31'd0, rsp_unsupported}, 1);
    check("R10 no fault", {31'd0, rsp_prot_fault}, 0);
    check("R10 no nocache", {31'd0, rsp_nocache_wr}, 0);
    check("R10 abs zero", rsp_abs, 0);
  endtask

  task automatic t_stall;
    set_ctl(0, 0, 0, 0);
    @(negedge clk);
    req_addr = 32'h0003_4008; req_kind = 0; req_valid = 1; rsp_ready = 0;
    @(negedge clk);
    req_valid = 0;
    check("R11 valid after accept", {31'd0, rsp_valid}, 1);
    check("R11 ready low", {31'd0, req_ready}, 0);
    req_valid = 1; req_addr = 32'h5000;
    @(negedge clk);
    req_valid = 0;
    check("R11 held valid", {31'd0, rsp_valid}, 1);
    check("R11 held data", rsp_abs, 32'h8);
    rsp_ready = 1;
    @(negedge clk);
    check("R11 single result", {31'd0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_remap; t_bytes; t_enable; t_space; t_kinds; t_unsup; t_stall;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule